// File: doc/BRIEF.md
# Paced Audio Sample Buffer with Serial DAC Output

This block sits between a sample producer that delivers data in bursts and a dual-channel 12-bit DAC on a serial link. The producer pushes 12-bit codes into a circular buffer whenever it has them. Playback does not depend on how full the buffer is. A programmable timer sets the rate, and on each of its ticks one code is taken out, placed in a 16-bit DAC command, and shifted out MSB first as an SPI master in mode 0. After chip select goes high, a separate active-low latch pulse makes the DAC update its output.

Status outputs report the buffer fill level, a comparison against a run-time low-watermark threshold, and two sticky error flags. The underrun flag sets when a tick finds the buffer empty. In that case the previous code is sent again. The overflow flag sets when a write arrives while the buffer is full, and that write is lost. One clear input resets both flags. A tick that lands while a frame is still shifting is held and served as soon as the frame has ended. With a 100 MHz system clock, a divider value of 4534 gives roughly 22.05 kHz. An integer divider cannot hit the rate exactly, and the small error is accepted.

Top module: `pcm_paced_dac`

## Requirements
- R1: Each frame holds chip select low for exactly 16 SCK periods and carries the word {1'b0 (channel A), 1'b0, 1'b1 (unity gain), 1'b1 (output active), code[11:0]}, i.e. 16'h3000 | code, MSB first. SCK idles low. MOSI is stable while SCK is high, and the DAC samples it on the rising edge.
- R2: Codes are played in the order in which they were written, including across pointer wrap.
- R3: With `rate_div` = N, a tick occurs every N+1 clocks. When frames are shorter than that period, consecutive chip-select falling edges are exactly N+1 clocks apart.
- R4: A tick that arrives while a frame is in progress is not lost. The next frame starts within a few clocks of the previous one ending (16·2·SCK_HALF+4 clocks apart).
- R5: A tick that finds the buffer empty resends the last played code (0 after reset) and sets the sticky `underrun` flag. A one-cycle `clr_flags` pulse clears it.
- R6: A write while the buffer is full is dropped and sets the sticky `overflow` flag, which `clr_flags` also clears. `fifo_full` is high when the fill level equals DEPTH.
- R7: `fill_level` rises by one per accepted write and falls by one per played code. A write and a play in the same cycle leave it unchanged.
- R8: `low_water` is high exactly when `fill_level` < `low_mark`.
- R9: `dac_ldac_n` goes low only while chip select is high, after each frame, for LATCH_CLKS (default 2) clocks.
- R10: Reset leaves chip select and latch high, SCK low, fill level zero and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Producer write strobe |
| wr_code | input | 12 | Sample code to store |
| rate_div | input | 16 | Tick period minus one, in clocks |
| low_mark | input | $clog2(DEPTH+1) | Low-watermark threshold |
| clr_flags | input | 1 | Clears the sticky underrun and overflow flags |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Active-low chip select |
| dac_ldac_n | output | 1 | Active-low DAC latch pulse |
| fill_level | output | $clog2(DEPTH+1) | Codes currently buffered |
| fifo_full | output | 1 | Buffer holds DEPTH codes |
| low_water | output | 1 | Fill level below low_mark |
| underrun | output | 1 | Sticky: a tick found the buffer empty |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
Fill level, full and the sticky flags are registered, so they are sampled at the falling edge one cycle after the write or clear that changes them. `low_water` is combinational on `fill_level` and `low_mark` and is read at the next falling edge. Frame contents are collected by a bench monitor on SCK rising edges and handed over when chip select rises. Pacing and latch width are measured in clock counts between chip-select falling edges and across the latch low time. The checks therefore wait for frame completion events and never for fixed delays. The underrun flag is read after the chip-select rise of the frame that set it.

// File: rtl/pcm_dac_pkg.sv
`timescale 1ns/1ps
package pcm_dac_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP, TX_LATCH} tx_state_e;

    // channel A, don't care, unity gain, output active
    localparam logic [3:0] CMD_HDR = 4'b0011;

    function automatic logic [15:0] make_cmd(input logic [11:0] code);
        return {CMD_HDR, code};
    endfunction
endpackage

// File: rtl/sample_ring.sv
`timescale 1ns/1ps
module sample_ring #(
    parameter int DEPTH = 4096,
    parameter int DW    = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          drop
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t r_q, r_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic push, pop;

    assign full     = (r_q.cnt == CW'(DEPTH));
    assign empty    = (r_q.cnt == '0);
    assign push     = push_req & ~full;
    assign pop      = pop_req & ~empty;
    assign drop     = push_req & full;
    assign pop_data = mem_q[r_q.rd];
    assign count    = r_q.cnt;

    always_comb begin
        r_d = r_q;
        if (push) r_d.wr = r_q.wr + 1'b1;
        if (pop)  r_d.rd = r_q.rd + 1'b1;
        case ({push, pop})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[r_q.wr] <= push_data;
    end

    p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> r_q.cnt == $past(r_q.cnt) + 1'b1);
    p_count_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop |=> $stable(r_q.cnt));
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/rate_tick.sv
`timescale 1ns/1ps
module rate_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] period_m1,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_t;

    tick_t t_q, t_d;

    assign tick = (t_q.cnt >= period_m1);

    always_comb begin
        t_d = t_q;
        t_d.cnt = tick ? '0 : t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/spi_frame_tx.sv
`timescale 1ns/1ps
module spi_frame_tx
    import pcm_dac_pkg::*;
#(
    parameter int SCK_HALF   = 2,
    parameter int LATCH_CLKS = 2,
    localparam int PMAX      = (SCK_HALF > LATCH_CLKS) ? SCK_HALF : LATCH_CLKS,
    localparam int PW        = $clog2(PMAX + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] word,
    output logic        busy,
    output logic        sck,
    output logic        mosi,
    output logic        cs_n,
    output logic        ldac_n
);
    typedef struct packed {
        tx_state_e     st;
        logic [15:0]   sh;
        logic [3:0]    bitn;
        logic [PW-1:0] ph;
        logic          sck;
        logic          cs_n;
        logic          ldac_n;
    } tx_t;

    tx_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            TX_IDLE: begin
                if (start) begin
                    s_d.st   = TX_SHIFT;
                    s_d.sh   = word;
                    s_d.bitn = 4'd15;
                    s_d.ph   = '0;
                    s_d.cs_n = 1'b0;
                end
            end
            TX_SHIFT: begin
                s_d.ph = s_q.ph + 1'b1;
                if (s_q.ph == PW'(SCK_HALF - 1)) begin
                    s_d.ph = '0;
                    if (!s_q.sck) begin
                        s_d.sck = 1'b1;
                    end else begin
                        s_d.sck = 1'b0;
                        if (s_q.bitn == 4'd0) begin
                            s_d.st   = TX_GAP;
                            s_d.cs_n = 1'b1;
                        end else begin
                            s_d.bitn = s_q.bitn - 1'b1;
                            s_d.sh   = {s_q.sh[14:0], 1'b0};
                        end
                    end
                end
            end
            TX_GAP: begin
                s_d.st     = TX_LATCH;
                s_d.ldac_n = 1'b0;
                s_d.ph     = '0;
            end
            default: begin
                s_d.ph = s_q.ph + 1'b1;
                if (s_q.ph == PW'(LATCH_CLKS - 1)) begin
                    s_d.ldac_n = 1'b1;
                    s_d.st     = TX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= TX_IDLE;
            s_q.cs_n   <= 1'b1;
            s_q.ldac_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.st != TX_IDLE);
    assign sck    = s_q.sck;
    assign mosi   = s_q.sh[15];
    assign cs_n   = s_q.cs_n;
    assign ldac_n = s_q.ldac_n;

    p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sck && $past(sck) |-> $stable(mosi));
    p_latch_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n |-> cs_n);
    p_latch_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ldac_n) |-> $past(cs_n));
endmodule

// File: rtl/pcm_paced_dac.sv
`timescale 1ns/1ps
module pcm_paced_dac
    import pcm_dac_pkg::*;
#(
    parameter int DEPTH      = 4096,
    parameter int DIV_W      = 16,
    parameter int SCK_HALF   = 2,
    parameter int LATCH_CLKS = 2,
    localparam int DW        = 12,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_code,
    input  logic [DIV_W-1:0] rate_div,
    input  logic [CW-1:0]    low_mark,
    input  logic             clr_flags,
    output logic             spi_sck,
    output logic             spi_mosi,
    output logic             spi_cs_n,
    output logic             dac_ldac_n,
    output logic [CW-1:0]    fill_level,
    output logic             fifo_full,
    output logic             low_water,
    output logic             underrun,
    output logic             overflow
);
    typedef struct packed {
        logic          pend;
        logic [DW-1:0] last;
        logic          underrun;
        logic          overflow;
    } ctl_t;

    ctl_t c_q, c_d;
    logic          tick, busy, start, empty, drop;
    logic [DW-1:0] head;
    logic [15:0]   cmd;

    rate_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .period_m1(rate_div), .tick(tick)
    );

    sample_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push_req(wr_en), .push_data(wr_code),
        .pop_req(start), .pop_data(head),
        .count(fill_level), .full(fifo_full), .empty(empty), .drop(drop)
    );

    assign start = c_q.pend & ~busy;
    assign cmd   = make_cmd(empty ? c_q.last : head);

    spi_frame_tx #(.SCK_HALF(SCK_HALF), .LATCH_CLKS(LATCH_CLKS)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .word(cmd), .busy(busy),
        .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n), .ldac_n(dac_ldac_n)
    );

    always_comb begin
        c_d = c_q;
        c_d.pend = (c_q.pend & ~start) | tick;
        if (start && !empty) c_d.last = head;
        if (clr_flags) begin
            c_d.underrun = 1'b0;
            c_d.overflow = 1'b0;
        end
        if (start && empty) c_d.underrun = 1'b1;
        if (drop)           c_d.overflow = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign low_water = (fill_level < low_mark);
    assign underrun  = c_q.underrun;
    assign overflow  = c_q.overflow;

    p_underrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start && empty |=> underrun);
    p_pend_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.pend && busy |=> c_q.pend);
    p_overflow_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && fifo_full |=> overflow && $stable(fill_level) || $fell(fill_level[0]) || fill_level != $past(fill_level));
    p_full_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> fill_level <= $past(fill_level));
endmodule

// File: tb/pcm_paced_dac_test.sv
`timescale 1ns/1ps
module pcm_paced_dac_test;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NV    = 10;
    // {stimulus code, expected DAC command word}
    localparam logic [27:0] VEC [NV] = '{
        {12'h000, 16'h3000}, {12'hFFF, 16'h3FFF}, {12'h800, 16'h3800},
        {12'h7FF, 16'h37FF}, {12'h123, 16'h3123}, {12'hA5A, 16'h3A5A},
        {12'h5A5, 16'h35A5}, {12'h001, 16'h3001}, {12'hFFE, 16'h3FFE},
        {12'h3C3, 16'h33C3}
    };

    logic clk = 0, rst_n = 0, wr_en = 0, clr_flags = 0;
    logic [11:0] wr_code = '0;
    logic [15:0] rate_div = 16'd199;
    logic [CW-1:0] low_mark = CW'(12);
    logic spi_sck, spi_mosi, spi_cs_n, dac_ldac_n, fifo_full, low_water, underrun, overflow;
    logic [CW-1:0] fill_level;

    pcm_paced_dac #(.DEPTH(DEPTH), .DIV_W(16), .SCK_HALF(2), .LATCH_CLKS(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
        .rate_div(rate_div), .low_mark(low_mark), .clr_flags(clr_flags),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .dac_ldac_n(dac_ldac_n), .fill_level(fill_level), .fifo_full(fifo_full),
        .low_water(low_water), .underrun(underrun), .overflow(overflow)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, nfr = 0, nb = 0, lw = 0;
    bit done = 0, ld_seen = 0;
    logic [15:0] sh = '0;
    logic [15:0] wbuf [256];
    int tstart [256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge spi_cs_n) begin
        if (nfr < 256) tstart[nfr] = cyc;
        nb = 0;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        sh = {sh[14:0], spi_mosi};
        nb++;
    end
    always @(posedge spi_cs_n) if (nb > 0) begin
        chk(nb == 16, "R1 bits per frame", nb, 16);
        if (nfr < 256) wbuf[nfr] = sh;
        nfr++;
        nb = 0;
    end

    always @(negedge clk) if (!dac_ldac_n) lw++;
    always @(negedge dac_ldac_n) begin
        chk(spi_cs_n == 1'b1, "R9 latch while cs high", int'(spi_cs_n), 1);
        lw = 0;
        ld_seen = 1;
    end
    always @(posedge dac_ldac_n) if (ld_seen)
        chk(lw == 2, "R9 latch width", lw, 2);

    task automatic wait_frames(input int n);
        while (nfr < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic [11:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_code = v;
    endtask

    task automatic end_put();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int nf;
        logic [11:0] r4v [4];
        logic [11:0] ov [18];
        r4v = '{12'h111, 12'hEEE, 12'h0F0, 12'hF0F};
        for (int i = 0; i < 18; i++) ov[i] = 12'(12'h100 + i * 37);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk(spi_cs_n == 1 && dac_ldac_n == 1 && spi_sck == 0, "R10 pins", {spi_cs_n, dac_ldac_n, spi_sck}, 3'b110);
        chk(fill_level == 0, "R10 fill", int'(fill_level), 0);
        chk(!underrun && !overflow, "R10 flags", {underrun, overflow}, 0);

        // R5: first tick with empty buffer resends reset code 0
        wait_frames(1);
        chk(wbuf[0] == 16'h3000, "R5 empty resend", wbuf[0], 16'h3000);
        chk(underrun == 1, "R5 underrun set", int'(underrun), 1);

        for (int i = 0; i < NV; i++) put(VEC[i][27:16]);
        end_put();
        pulse_clr();
        chk(underrun == 0, "R5 clear", int'(underrun), 0);
        chk(fill_level == CW'(NV), "R7 fill after burst", int'(fill_level), NV);
        chk(low_water == 1, "R8 below mark", int'(low_water), 1);
        low_mark = CW'(8);
        @(negedge clk);
        chk(low_water == 0, "R8 above mark", int'(low_water), 0);

        wait_frames(2);
        chk(fill_level == CW'(NV - 1), "R7 fill after play", int'(fill_level), NV - 1);
        wait_frames(1 + NV);
        for (int i = 0; i < NV; i++)
            chk(wbuf[i + 1] == VEC[i][15:0], "R1 R2 vector word", wbuf[i + 1], VEC[i][15:0]);
        for (int i = 1; i <= NV; i++)
            chk(tstart[i] - tstart[i - 1] == 200, "R3 tick period", tstart[i] - tstart[i - 1], 200);

        wait_frames(2 + NV);
        chk(wbuf[1 + NV] == VEC[NV - 1][15:0], "R5 last resent", wbuf[1 + NV], VEC[NV - 1][15:0]);
        chk(underrun == 1, "R5 underrun again", int'(underrun), 1);

        // R4: ticks faster than a frame
        nf = nfr;
        for (int i = 0; i < 4; i++) put(r4v[i]);
        end_put();
        rate_div = 16'd9;
        wait_frames(nf + 4);
        for (int i = 0; i < 4; i++)
            chk(wbuf[nf + i] == {4'h3, r4v[i]}, "R4 R2 held tick word", wbuf[nf + i], {4'h3, r4v[i]});
        for (int i = 1; i < 4; i++)
            chk(tstart[nf + i] - tstart[nf + i - 1] >= 64 && tstart[nf + i] - tstart[nf + i - 1] <= 72,
                "R4 back-to-back interval", tstart[nf + i] - tstart[nf + i - 1], 68);

        // R6: overflow with slow ticks
        rate_div = 16'hFFFF;
        repeat (300) @(negedge clk);
        pulse_clr();
        nf = nfr;
        for (int i = 0; i < 18; i++) put(ov[i]);
        end_put();
        chk(fill_level == CW'(DEPTH), "R6 fill capped", int'(fill_level), DEPTH);
        chk(fifo_full == 1, "R6 full", int'(fifo_full), 1);
        chk(overflow == 1, "R6 overflow set", int'(overflow), 1);
        pulse_clr();
        chk(overflow == 0, "R6 overflow clear", int'(overflow), 0);
        rate_div = 16'd199;
        wait_frames(nf + DEPTH + 1);
        for (int i = 0; i < DEPTH; i++)
            chk(wbuf[nf + i] == {4'h3, ov[i]}, "R6 R2 wrap order", wbuf[nf + i], {4'h3, ov[i]});
        chk(wbuf[nf + DEPTH] == {4'h3, ov[DEPTH - 1]}, "R6 dropped not played", wbuf[nf + DEPTH], {4'h3, ov[DEPTH - 1]});
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule